// File: doc/BRIEF.md
# USB Endpoint Receive Status Tracker

This block follows every data packet that reaches the endpoints of a full-speed USB peripheral and leaves a summary of each one in registers that a CPU can read. Each endpoint has two register sets, A and B. The packet engine in front of it reports four kinds of event: a packet opening (endpoint, token kind, data PID), each received data byte, a CRC or PID error, and the packet closing. Bit-level work, CRC computation, token decoding and the data buffer belong to other blocks.

Each set holds a base length that the CPU programs, a residual count and a status byte. When a receiving packet closes, the residual count is the base length minus the bytes that actually arrived, and it saturates at zero. The status byte records overflow, setup, data toggle, error and acknowledge. A write strobe tells the data buffer which bytes to keep. Bytes past the base length are not written to the buffer. The set that a packet updates is the one selected by `cur_set` when the packet opens. Both registers of that set change together, and a one-cycle `done` pulse is raised at the same moment.

Top module: `usb_ep_stat_tracker`

## Requirements
- R1: After reset, every base length, status and count register reads 0, and `done` and `buf_wr_en` are low.
- R2: `cpu_addr[5:4]` selects the endpoint. Offsets 2, 3 and 4 in `cpu_addr[3:0]` are the base length, status and count of set A. Offsets A, B and C are the same three registers of set B. Only the base length registers accept writes. Writes to a status or count offset leave that register unchanged. All other offsets read 0.
- R3: After a receiving packet (OUT or SETUP), count reads base − received when fewer bytes than the base length arrived, and 0 otherwise. The base length used is the value in place when the packet opened.
- R4: Status bit 5 (overflow) is set only for an OUT packet that carries more bytes than the base length.
- R5: Status bit 4 (setup) is 1 when the token was SETUP and 0 for every other token.
- R6: Status bit 3 (sequence) equals `pkt_pid1` as sampled when the packet opened (0 = DATA0, 1 = DATA1).
- R7: Status bit 1 (error) is 1 when `pkt_err` was high in any cycle from the cycle after the opening through the closing cycle.
- R8: Status bit 0 (ACK) is 1 exactly when both error and overflow are 0. Bits 7, 6 and 2 always read 0.
- R9: For OUT and SETUP packets, `buf_wr_en` is high in the cycle of each received byte while the bytes so far are fewer than the base length. It is never high for other tokens.
- R10: A packet whose `pkt_end` is sampled at edge t updates status and count at edge t+1. At the same edge, `done` rises for exactly one cycle with `done_ep`/`done_set` naming the updated set. That set is `cur_set` as sampled at the opening.
- R11: Token codes on `pkt_tok` are 0 = OUT, 1 = IN, 2 = SETUP and 3 = reserved. Codes 1 and 3 do not receive. They update the status with overflow and setup at 0, leave the count unchanged, and ignore byte strobes.
- R12: A byte strobe in the same cycle as `pkt_end` is counted. A `pkt_end` with no open packet causes no update and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Packet opens this cycle |
| pkt_ep | input | 2 | Endpoint of the opening packet |
| pkt_tok | input | 2 | Token kind (0 OUT, 1 IN, 2 SETUP, 3 reserved) |
| pkt_pid1 | input | 1 | Data PID is DATA1 |
| cur_set | input | 1 | Register set selected at packet opening (0 A, 1 B) |
| rx_byte_vld | input | 1 | One data byte received this cycle |
| pkt_err | input | 1 | CRC or PID error reported this cycle |
| pkt_end | input | 1 | Packet closes this cycle |
| buf_wr_en | output | 1 | Store the current byte in the buffer |
| cpu_addr | input | 6 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| done | output | 1 | One-cycle pulse: a set was updated |
| done_ep | output | 2 | Endpoint of the updated set |
| done_set | output | 1 | Set of the updated registers |

## Verification
The last data byte and the packet close can arrive in the same cycle. In that case the byte count that decides residual, overflow and the buffer strobe must include the byte that came with the close, and no byte may be lost or counted twice. The random phase draws, for each packet, whether the final byte shares the cycle with `pkt_end`, and also draws the byte counts around the base length. Residual, overflow and the number of `buf_wr_en` pulses are then compared with values the bench computes from the number of bytes it sent. Errors that share the closing cycle are drawn the same way and are checked through the error and ACK bits.

// File: rtl/usb_eps_pkg.sv
`timescale 1ns/1ps
package usb_eps_pkg;
  localparam int BYTE_W = 8;
  localparam int RCV_W  = BYTE_W + 1;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  // register offsets inside an endpoint's 16-byte window
  localparam logic [3:0] OFS_BASE_A = 4'h2;
  localparam logic [3:0] OFS_STAT_A = 4'h3;
  localparam logic [3:0] OFS_CNT_A  = 4'h4;
  localparam logic [3:0] OFS_BASE_B = 4'hA;
  localparam logic [3:0] OFS_STAT_B = 4'hB;
  localparam logic [3:0] OFS_CNT_B  = 4'hC;

  // status bit positions
  localparam int ST_OVF   = 5;
  localparam int ST_SETUP = 4;
  localparam int ST_SEQ   = 3;
  localparam int ST_TMO   = 2;
  localparam int ST_ERR   = 1;
  localparam int ST_ACK   = 0;

  function automatic logic receives_f(input tok_e t);
    return (t == TOK_OUT) || (t == TOK_SETUP);
  endfunction

  // base length minus bytes seen, floored at zero
  function automatic logic [BYTE_W-1:0] residual_f(input logic [BYTE_W-1:0] base,
                                                   input logic [RCV_W-1:0]  rcvd);
    if (rcvd >= {1'b0, base}) return '0;
    return base - rcvd[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] status_f(input logic ovf, input logic setup,
                                                 input logic seq, input logic err);
    logic [BYTE_W-1:0] s;
    s           = '0;
    s[ST_OVF]   = ovf;
    s[ST_SETUP] = setup;
    s[ST_SEQ]   = seq;
    s[ST_ERR]   = err;
    s[ST_ACK]   = !err && !ovf;
    return s;
  endfunction
endpackage

// File: rtl/eps_rx_ctx.sv
`timescale 1ns/1ps
module eps_rx_ctx
  import usb_eps_pkg::*;
#(
  parameter int EP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic [EP_W-1:0]   pkt_ep,
  input  tok_e              pkt_tok,
  input  logic              pkt_pid1,
  input  logic              cur_set,
  input  logic              rx_byte_vld,
  input  logic              pkt_err,
  input  logic              pkt_end,
  input  logic [BYTE_W-1:0] lk_base,
  output logic              buf_wr_en,
  output logic              c_vld,
  output logic [EP_W-1:0]   c_ep,
  output logic              c_set,
  output tok_e              c_tok,
  output logic [BYTE_W-1:0] c_stat,
  output logic [BYTE_W-1:0] c_res,
  output logic              c_wcnt
);
  logic              act_q;
  logic [EP_W-1:0]   ep_q;
  logic              set_q;
  tok_e              tok_q;
  logic              seq_q;
  logic              err_q;
  logic [BYTE_W-1:0] base_q;
  logic [RCV_W-1:0]  rcvd_q;

  logic              byte_in;
  logic              sat;
  logic              step;
  logic              end_ok;
  logic [RCV_W-1:0]  rcvd_fin;
  logic              err_fin;
  logic              ovf_fin;

  assign byte_in   = act_q && rx_byte_vld && receives_f(tok_q);
  assign sat       = rcvd_q > {1'b0, base_q};
  assign step      = byte_in && !sat;
  assign buf_wr_en = byte_in && (rcvd_q < {1'b0, base_q});
  assign end_ok    = act_q && pkt_end;
  assign rcvd_fin  = rcvd_q + RCV_W'(step);
  assign err_fin   = err_q || pkt_err;
  assign ovf_fin   = (tok_q == TOK_OUT) && (rcvd_fin > {1'b0, base_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ep_q   <= '0;
      set_q  <= 1'b0;
      tok_q  <= TOK_OUT;
      seq_q  <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      rcvd_q <= '0;
      c_vld  <= 1'b0;
      c_ep   <= '0;
      c_set  <= 1'b0;
      c_tok  <= TOK_OUT;
      c_stat <= '0;
      c_res  <= '0;
      c_wcnt <= 1'b0;
    end else begin
      c_vld <= end_ok;
      if (end_ok) begin
        c_ep   <= ep_q;
        c_set  <= set_q;
        c_tok  <= tok_q;
        c_stat <= status_f(ovf_fin, tok_q == TOK_SETUP, seq_q, err_fin);
        c_res  <= residual_f(base_q, rcvd_fin);
        c_wcnt <= receives_f(tok_q);
      end
      if (pkt_start) begin
        act_q  <= 1'b1;
        ep_q   <= pkt_ep;
        set_q  <= cur_set;
        tok_q  <= pkt_tok;
        seq_q  <= pkt_pid1;
        base_q <= lk_base;
        rcvd_q <= '0;
        err_q  <= 1'b0;
      end else if (end_ok) begin
        act_q <= 1'b0;
      end else begin
        if (step) rcvd_q <= rcvd_fin;
        if (act_q && pkt_err) err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eps_reg_bank.sv
`timescale 1ns/1ps
module eps_reg_bank
  import usb_eps_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic [EP_W-1:0]   lk_ep,
  input  logic              lk_set,
  output logic [BYTE_W-1:0] lk_base,
  input  logic              up_vld,
  input  logic [EP_W-1:0]   up_ep,
  input  logic              up_set,
  input  logic [BYTE_W-1:0] up_stat,
  input  logic [BYTE_W-1:0] up_res,
  input  logic              up_wcnt
);
  localparam int NSLOT = NUM_EP * 2;

  logic [BYTE_W-1:0] base_r [NSLOT];
  logic [BYTE_W-1:0] stat_r [NSLOT];
  logic [BYTE_W-1:0] cnt_r  [NSLOT];

  logic [3:0]      ofs;
  logic [EP_W-1:0] aep;
  logic [EP_W:0]   ridx;

  assign ofs  = cpu_addr[3:0];
  assign aep  = cpu_addr[ADDR_W-1:4];
  assign ridx = {aep, ofs[3]};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic            SETB   = 1'((g % 2) == 1);
    localparam logic [EP_W-1:0] EPN    = EP_W'(g / 2);
    localparam logic [3:0]      BOFS   = SETB ? OFS_BASE_B : OFS_BASE_A;
    logic base_hit;
    logic upd_hit;
    assign base_hit = cpu_wr && (aep == EPN) && (ofs == BOFS);
    assign upd_hit  = up_vld && (up_ep == EPN) && (up_set == SETB);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r[g] <= '0;
        stat_r[g] <= '0;
        cnt_r[g]  <= '0;
      end else begin
        if (base_hit) base_r[g] <= cpu_wdata;
        if (upd_hit) begin
          stat_r[g] <= up_stat;
          if (up_wcnt) cnt_r[g] <= up_res;
        end
      end
    end
  end

  assign lk_base = base_r[{lk_ep, lk_set}];

  always_comb begin
    case (ofs)
      OFS_BASE_A, OFS_BASE_B: cpu_rdata = base_r[ridx];
      OFS_STAT_A, OFS_STAT_B: cpu_rdata = stat_r[ridx];
      OFS_CNT_A,  OFS_CNT_B:  cpu_rdata = cnt_r[ridx];
      default:                cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_stat_tracker.sv
`timescale 1ns/1ps
module usb_ep_stat_tracker
  import usb_eps_pkg::*;
#(
  parameter  int NUM_EP = 4,
  localparam int EP_W   = $clog2(NUM_EP),
  localparam int ADDR_W = EP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic [1:0]        pkt_tok,
  input  logic              pkt_pid1,
  input  logic              cur_set,
  input  logic              rx_byte_vld,
  input  logic              pkt_err,
  input  logic              pkt_end,
  output logic              buf_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              done,
  output logic [EP_W-1:0]   done_ep,
  output logic              done_set
);
  // named internal events, visible to the bound checker
  logic              commit_vld;
  logic [EP_W-1:0]   commit_ep;
  logic              commit_set;
  tok_e              commit_tok;
  logic [BYTE_W-1:0] commit_stat;
  logic [BYTE_W-1:0] commit_res;
  logic              commit_wcnt;
  logic [BYTE_W-1:0] start_base;

  eps_rx_ctx #(.EP_W(EP_W)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (pkt_start),
    .pkt_ep     (pkt_ep),
    .pkt_tok    (tok_e'(pkt_tok)),
    .pkt_pid1   (pkt_pid1),
    .cur_set    (cur_set),
    .rx_byte_vld(rx_byte_vld),
    .pkt_err    (pkt_err),
    .pkt_end    (pkt_end),
    .lk_base    (start_base),
    .buf_wr_en  (buf_wr_en),
    .c_vld      (commit_vld),
    .c_ep       (commit_ep),
    .c_set      (commit_set),
    .c_tok      (commit_tok),
    .c_stat     (commit_stat),
    .c_res      (commit_res),
    .c_wcnt     (commit_wcnt)
  );

  eps_reg_bank #(.NUM_EP(NUM_EP), .EP_W(EP_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .lk_ep    (pkt_ep),
    .lk_set   (cur_set),
    .lk_base  (start_base),
    .up_vld   (commit_vld),
    .up_ep    (commit_ep),
    .up_set   (commit_set),
    .up_stat  (commit_stat),
    .up_res   (commit_res),
    .up_wcnt  (commit_wcnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      done_ep  <= '0;
      done_set <= 1'b0;
    end else begin
      done <= commit_vld;
      if (commit_vld) begin
        done_ep  <= commit_ep;
        done_set <= commit_set;
      end
    end
  end
endmodule

// File: rtl/eps_checker.sv
`timescale 1ns/1ps
module eps_checker
  import usb_eps_pkg::*;
#(
  parameter int EP_W   = 2,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_end,
  input logic              rx_byte_vld,
  input logic              buf_wr_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BYTE_W-1:0] cpu_rdata,
  input logic              done,
  input logic              commit_vld,
  input tok_e              commit_tok,
  input logic [BYTE_W-1:0] commit_stat,
  input logic [BYTE_W-1:0] commit_res
);
  logic stat_addr;
  assign stat_addr = (cpu_addr[3:0] == OFS_STAT_A) || (cpu_addr[3:0] == OFS_STAT_B);

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_addr |-> (cpu_rdata[7:6] == 2'b00 && !cpu_rdata[ST_TMO]));

  assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> !(commit_stat[ST_ACK] && (commit_stat[ST_ERR] || commit_stat[ST_OVF])));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && commit_stat[ST_OVF]) |-> (commit_tok == TOK_OUT));

  assert_ovf_zero_res_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && commit_stat[ST_OVF]) |-> (commit_res == '0));

  assert_setup_tok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> (commit_stat[ST_SETUP] == (commit_tok == TOK_SETUP)));

  assert_done_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pkt_end, 2));

  assert_bufwr_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> rx_byte_vld);
endmodule

bind usb_ep_stat_tracker eps_checker #(.EP_W(EP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pkt_end    (pkt_end),
  .rx_byte_vld(rx_byte_vld),
  .buf_wr_en  (buf_wr_en),
  .cpu_addr   (cpu_addr),
  .cpu_rdata  (cpu_rdata),
  .done       (done),
  .commit_vld (commit_vld),
  .commit_tok (commit_tok),
  .commit_stat(commit_stat),
  .commit_res (commit_res)
);

// File: tb/usb_ep_stat_tracker_tb.sv
`timescale 1ns/1ps
module usb_ep_stat_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_start = 1'b0;
  logic [1:0] pkt_ep = '0;
  logic [1:0] pkt_tok = '0;
  logic       pkt_pid1 = 1'b0;
  logic       cur_set = 1'b0;
  logic       rx_byte_vld = 1'b0;
  logic       pkt_err = 1'b0;
  logic       pkt_end = 1'b0;
  logic       buf_wr_en;
  logic [5:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       done;
  logic [1:0] done_ep;
  logic       done_set;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // bench-side model of the 8 register sets (index = ep*2+set)
  int m_base [8];
  int m_stat [8];
  int m_cnt  [8];

  always #5 clk = ~clk;

  usb_ep_stat_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_ep(pkt_ep),
    .pkt_tok(pkt_tok), .pkt_pid1(pkt_pid1), .cur_set(cur_set),
    .rx_byte_vld(rx_byte_vld), .pkt_err(pkt_err), .pkt_end(pkt_end),
    .buf_wr_en(buf_wr_en), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .done(done),
    .done_ep(done_ep), .done_set(done_set)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] reg_addr(input int ep, input int set, input int kind);
    // kind 0 base, 1 status, 2 count
    return 6'((ep << 4) + (set * 8) + 2 + kind);
  endfunction

  // expected status: bits listed in the requirements, built one by one
  function automatic int exp_status(input int tok, input int pid, input int err,
                                    input int n, input int base);
    int ovf = (tok == 0 && n > base) ? 1 : 0;
    int v = 0;
    if (ovf != 0) v += 32;
    if (tok == 2) v += 16;
    if (pid != 0) v += 8;
    if (err != 0) v += 2;
    if (err == 0 && ovf == 0) v += 1;
    return v;
  endfunction

  function automatic int exp_residual(input int base, input int n);
    int d = base - n;
    return (d < 0) ? 0 : d;
  endfunction

  task automatic read_reg(input int ep, input int set, input int kind, output int v);
    cpu_addr = reg_addr(ep, set, kind);
    #1;
    v = int'(cpu_rdata);
  endtask

  task automatic write_addr(input logic [5:0] a, input int d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'(d); cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_base(input int ep, input int set, input int b);
    write_addr(reg_addr(ep, set, 0), b);
    m_base[ep*2+set] = b;
  endtask

  // errpos: -1 none, i < n-? : with byte i, n : in the closing cycle
  task automatic run_pkt(input int ep, input int set, input int tok, input int pid,
                         input int n, input int errpos, input bit eoe, input string req);
    int wr_cnt = 0;
    int nsep;
    int idx = ep*2 + set;
    int base = m_base[idx];
    int v;
    int err = (errpos >= 0) ? 1 : 0;
    bit rcv = (tok == 0 || tok == 2);
    @(negedge clk);
    pkt_start = 1'b1; pkt_ep = 2'(ep); pkt_tok = 2'(tok); pkt_pid1 = pid[0]; cur_set = set[0];
    @(negedge clk);
    pkt_start = 1'b0; cur_set = ~set[0]; pkt_pid1 = ~pid[0];
    nsep = (eoe && n > 0) ? n - 1 : n;
    for (int i = 0; i < nsep; i++) begin
      rx_byte_vld = 1'b1;
      pkt_err = (errpos == i);
      #1;
      if (buf_wr_en) wr_cnt++;
      @(negedge clk);
    end
    rx_byte_vld = (eoe && n > 0);
    pkt_err = (errpos >= nsep);
    pkt_end = 1'b1;
    #1;
    if (buf_wr_en) wr_cnt++;
    @(negedge clk);
    pkt_end = 1'b0; rx_byte_vld = 1'b0; pkt_err = 1'b0;
    check({req, " R10 done not yet"}, int'(done), 0);
    m_stat[idx] = exp_status(tok, pid, err, n, base);
    if (rcv) m_cnt[idx] = exp_residual(base, n);
    @(negedge clk);
    check({req, " R10 done pulse"}, int'(done), 1);
    check({req, " R10 done_ep"}, int'(done_ep), ep);
    check({req, " R10 done_set"}, int'(done_set), set);
    read_reg(ep, set, 1, v);
    check({req, " R4 R5 R6 R7 R8 status"}, v, m_stat[idx]);
    read_reg(ep, set, 2, v);
    check({req, " R3 R11 count"}, v, m_cnt[idx]);
    check({req, " R9 buffer writes"}, wr_cnt, rcv ? ((n < base) ? n : base) : 0);
    @(negedge clk);
    check({req, " R10 single pulse"}, int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_stat[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check("R1 done at reset", int'(done), 0);
    check("R1 buf_wr_en at reset", int'(buf_wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 3; k++) begin
          read_reg(e, s, k, v);
          check("R1 register reset value", v, 0);
        end

    // R2 address map: base write/readback and unused offsets
    set_base(2, 1, 8'h5A);
    read_reg(2, 1, 0, v);
    check("R2 base B ep2 readback", v, 8'h5A);
    read_reg(2, 0, 0, v);
    check("R2 base A ep2 untouched", v, 0);
    write_addr(6'h20, 8'hFF);
    cpu_addr = 6'h20; #1;
    check("R2 unused offset reads 0", int'(cpu_rdata), 0);

    // R3 directed: 64 base, 16 bytes -> 48
    set_base(1, 0, 64);
    run_pkt(1, 0, 0, 1, 16, -1, 1'b0, "R3 64/16");
    // exact length: no overflow, count 0
    set_base(0, 1, 8);
    run_pkt(0, 1, 0, 0, 8, -1, 1'b1, "R3 exact");
    // one byte over on OUT: overflow
    run_pkt(0, 1, 0, 1, 9, -1, 1'b0, "R4 over by one");
    // SETUP over length: no overflow bit, setup set
    run_pkt(0, 1, 2, 0, 12, -1, 1'b1, "R5 setup long");
    // zero base, zero bytes
    run_pkt(3, 0, 0, 0, 0, -1, 1'b0, "R3 empty");
    // error in closing cycle
    set_base(3, 1, 10);
    run_pkt(3, 1, 0, 1, 4, 4, 1'b1, "R7 err at end");
    // IN token with byte strobes: count untouched
    run_pkt(3, 1, 1, 1, 5, -1, 1'b0, "R11 IN");
    run_pkt(3, 1, 3, 0, 2, 0, 1'b0, "R11 reserved tok");
    // max base, two bytes beyond
    set_base(2, 0, 255);
    run_pkt(2, 0, 0, 0, 257, -1, 1'b1, "R4 max base");

    // R2: writes to status/count offsets are ignored
    write_addr(reg_addr(1, 0, 1), 8'hFF);
    write_addr(reg_addr(1, 0, 2), 8'h11);
    read_reg(1, 0, 1, v);
    check("R2 status write ignored", v, m_stat[2]);
    read_reg(1, 0, 2, v);
    check("R2 count write ignored", v, m_cnt[2]);

    // R12: end with no open packet
    @(negedge clk);
    pkt_end = 1'b1; rx_byte_vld = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0; rx_byte_vld = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R12 stray end gives no done", int'(done), 0);
    end
    read_reg(2, 0, 1, v);
    check("R12 stray end leaves status", v, m_stat[4]);

    // random phase
    for (int t = 0; t < 120; t++) begin
      int ep = int'($urandom_range(0, 3));
      int st = int'($urandom_range(0, 1));
      int tk = int'($urandom_range(0, 3));
      int n;
      int ep_err;
      if ($urandom_range(0, 3) == 0) set_base(ep, st, int'($urandom_range(0, 24)));
      n = int'($urandom_range(0, m_base[ep*2+st] + 4));
      ep_err = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, n)) : -1;
      run_pkt(ep, st, tk, int'($urandom_range(0, 1)), n, ep_err,
              1'($urandom_range(0, 1)), "R12 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule